// File: doc/BRIEF.md
# Cascadable Parallel-to-Serial Shift Register

This block turns a parallel word into a serial bit stream. On a rising clock edge, while the clock enable is asserted, it does one of two things. If the load select is asserted, it captures the parallel word. Otherwise it shifts every stage one place toward the last stage, and the first stage takes the serial input. When the enable is deasserted, edges do nothing and the contents are held. An active-low clear drives every stage to zero at once, with no clock needed, and it overrides all other inputs.

Only the last stage is visible, on the serial output, so a loaded word leaves the block most significant bit first. Longer converters are built by tying one instance's serial output to the next instance's serial input. All instances share the clock, enable, load select and clear. The instance whose serial input is driven from another instance emits its own word first, then the bits that arrive from upstream.

Top module: `pso_shift_reg`

## Requirements
- R1: The register holds WIDTH stages (default 8), numbered 0 to WIDTH-1. `ser_out` always equals stage WIDTH-1.
- R2: With `ce_n` low and `ld_n` low at a rising edge, stage i takes `par_in[i]` for every i. Load wins over shift.
- R3: With `ce_n` low and `ld_n` high at a rising edge, stage 0 takes `ser_in` and stage i takes the old stage i-1 for i from 1 to WIDTH-1.
- R4: With `ce_n` high at a rising edge, the register keeps its contents whatever `ld_n`, `ser_in` and `par_in` carry.
- R5: While `clr_n` is low, every stage is 0 and `ser_out` is 0, from the moment `clr_n` falls and with no clock edge needed. Clear overrides load, shift and hold.
- R6: After `clr_n` rises, the register stays all zero until the first rising edge with `ce_n` low.
- R7: Two instances, with the upstream `ser_out` tied to the downstream `ser_in`, form a 2*WIDTH-bit converter. After a load it emits the downstream word MSB first, then the upstream word MSB first.
- R8: After a load of word P, the value of `ser_out` after k further shift edges (k = 0 to WIDTH-1) is P[WIDTH-1-k]. After WIDTH shifts, the serial input bits appear at `ser_out` in the order they were applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| ce_n | input | 1 | Synchronous clock enable, active low |
| ld_n | input | 1 | Parallel load select, active low (high = shift) |
| ser_in | input | 1 | Serial input into stage 0 |
| par_in | input | WIDTH | Parallel word, bit i to stage i |
| ser_out | output | 1 | Last stage (WIDTH-1) |

## Verification
Two behaviours are hard to reach from the ports. The first is the clear acting between edges: the bench pulls `clr_n` low in the middle of a clock period, right after loading all ones, and samples `ser_out` a few nanoseconds later, before any edge could explain a change. The second is a hold that hides a pending load or shift: the bench parks a word part-way through shifting and toggles `ld_n` and `ser_in` with `ce_n` high. It then drains the remaining bits and shows that none of the hidden stages changed.

// File: rtl/pso_pkg.sv
package pso_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } pso_op_e;

endpackage

// File: rtl/pso_mode_decode.sv
module pso_mode_decode
    import pso_pkg::*;
(
    input  logic    ce_n,
    input  logic    ld_n,
    output pso_op_e op
);

    // Enable is checked first, then load takes priority over shift.
    always_comb begin
        if (ce_n) begin
            op = OP_HOLD;
        end else if (!ld_n) begin
            op = OP_LOAD;
        end else begin
            op = OP_SHIFT;
        end
    end

endmodule

// File: rtl/pso_stage_reg.sv
module pso_stage_reg
    import pso_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  pso_op_e          op,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] word_q,
    output logic             armed_q
);

    localparam int LAST = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] word;
        logic             armed;
    } stage_t;

    stage_t           st_d;
    stage_t           st_q;
    logic [WIDTH-1:0] shift_src;

    // Source of each stage when shifting: stage 0 from the serial input,
    // the rest from their lower neighbour.
    for (genvar g = 0; g < WIDTH; g++) begin : g_src
        if (g == 0) begin : g_first
            assign shift_src[g] = ser_in;
        end else begin : g_rest
            assign shift_src[g] = st_q.word[g-1];
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.armed = 1'b1;
        unique case (op)
            OP_LOAD:  st_d.word = par_in;
            OP_SHIFT: st_d.word = shift_src;
            default:  st_d.word = st_q.word;
        endcase
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_q  = st_q.word;
    assign armed_q = st_q.armed;

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!clr_n)
        (armed_q && op == OP_LOAD) |=> (word_q == $past(par_in))); // R2

    AST_SHIFT_ADVANCE: assert property (@(posedge clk) disable iff (!clr_n)
        (armed_q && op == OP_SHIFT) |=>
            (word_q[0] == $past(ser_in) && word_q[LAST:1] == $past(word_q[LAST-1:0]))); // R3

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!clr_n)
        (armed_q && op == OP_HOLD) |=> $stable(word_q)); // R4

    AST_CLEAR_ZERO: assert property (@(posedge clk)
        (!clr_n) |-> (word_q == '0 && !armed_q)); // R5

    AST_IDLE_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!clr_n)
        (!armed_q && op == OP_HOLD) |=> (word_q == '0)); // R6

endmodule

// File: rtl/pso_shift_reg.sv
module pso_shift_reg
    import pso_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             ce_n,
    input  logic             ld_n,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic             ser_out
);

    localparam int LAST = WIDTH - 1;

    pso_op_e          op;
    logic [WIDTH-1:0] word;
    logic             armed;

    pso_mode_decode u_decode (
        .ce_n (ce_n),
        .ld_n (ld_n),
        .op   (op)
    );

    pso_stage_reg #(
        .WIDTH (WIDTH)
    ) u_stages (
        .clk     (clk),
        .clr_n   (clr_n),
        .op      (op),
        .ser_in  (ser_in),
        .par_in  (par_in),
        .word_q  (word),
        .armed_q (armed)
    );

    assign ser_out = word[LAST];

    AST_SEROUT_ORDER: assert property (@(posedge clk) disable iff (!clr_n)
        (armed && !ce_n && ld_n) |=> (ser_out == $past(word[LAST-1]))); // R8

    AST_LOAD_MSB_OUT: assert property (@(posedge clk) disable iff (!clr_n)
        (armed && !ce_n && !ld_n) |=> (ser_out == $past(par_in[LAST]))); // R1

endmodule

// File: tb/pso_shift_reg_tb_top.sv
`timescale 1ns/1ps
module pso_shift_reg_tb_top;

    localparam int W = 8;
    localparam int CYCLES_MAX = 200000;

    logic         clk = 1'b0;
    logic         clr_n = 1'b0;
    logic         ce_n = 1'b1;
    logic         ld_n = 1'b1;
    logic         tb_ser = 1'b0;
    logic         cas_mode = 1'b0;
    logic [W-1:0] par_dn = '0;
    logic [W-1:0] par_up = '0;
    logic         dn_ser_in;
    logic         up_out;
    logic         ser_out;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    assign dn_ser_in = cas_mode ? up_out : tb_ser;

    pso_shift_reg #(.WIDTH(W)) dut_i (
        .clk(clk), .clr_n(clr_n), .ce_n(ce_n), .ld_n(ld_n),
        .ser_in(dn_ser_in), .par_in(par_dn), .ser_out(ser_out)
    );

    pso_shift_reg #(.WIDTH(W)) up_i (
        .clk(clk), .clr_n(clr_n), .ce_n(ce_n), .ld_n(ld_n),
        .ser_in(tb_ser), .par_in(par_up), .ser_out(up_out)
    );

    task automatic chk(input logic act, input logic exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
        end
    endtask

    // Drive after the falling edge, sample 1 ns after the rising edge.
    task automatic step(input logic c, input logic l, input logic s);
        @(negedge clk);
        ce_n = c; ld_n = l; tb_ser = s;
        @(posedge clk);
        #1;
    endtask

    task automatic load_dn(input logic [W-1:0] v);
        par_dn = v;
        step(1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_reset_idle();
        clr_n = 1'b0;
        #5;
        chk(ser_out, 1'b0, "R5 clear state");
        @(negedge clk);
        clr_n = 1'b1;
        par_dn = '1;
        for (int i = 0; i < 3; i++) begin
            step(1'b1, 1'b0, 1'b1);
            chk(ser_out, 1'b0, "R6 idle after clear, disabled edges");
        end
        for (int i = 0; i < W; i++) begin
            chk(ser_out, 1'b0, "R6 contents zero");
            step(1'b0, 1'b1, 1'b0);
        end
    endtask

    task automatic t_load_shift(input logic [W-1:0] v, input logic [W-1:0] sin);
        load_dn(v);
        for (int k = 0; k < W; k++) begin
            chk(ser_out, v[W-1-k], "R8 msb-first order");
            step(1'b0, 1'b1, sin[W-1-k]);
        end
        for (int k = 0; k < W; k++) begin
            chk(ser_out, sin[W-1-k], "R3 serial input follows");
            step(1'b0, 1'b1, 1'b0);
        end
    endtask

    task automatic t_hold(input logic [W-1:0] v);
        load_dn(v);
        step(1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b0);
        par_dn = ~v;
        for (int i = 0; i < 4; i++) begin
            step(1'b1, i[0], ~i[0]);
            chk(ser_out, v[W-3], "R4 hold ignores load/shift");
        end
        for (int k = 2; k < W; k++) begin
            chk(ser_out, v[W-1-k], "R4 hidden stages kept");
            step(1'b0, 1'b1, 1'b0);
        end
    endtask

    task automatic t_load_priority(input logic [W-1:0] a, input logic [W-1:0] b);
        load_dn(a);
        step(1'b0, 1'b1, 1'b1);
        par_dn = b;
        step(1'b0, 1'b0, 1'b1);
        for (int k = 0; k < W; k++) begin
            chk(ser_out, b[W-1-k], "R2 load mid-stream replaces word");
            step(1'b0, 1'b1, 1'b0);
        end
    endtask

    task automatic t_async_clear();
        load_dn('1);
        chk(ser_out, 1'b1, "R1 last stage visible");
        @(negedge clk);
        #3;
        clr_n = 1'b0;
        #2;
        chk(ser_out, 1'b0, "R5 clear between edges");
        ce_n = 1'b0; ld_n = 1'b0;
        @(posedge clk);
        #1;
        chk(ser_out, 1'b0, "R5 clear overrides load");
        @(negedge clk);
        clr_n = 1'b1;
        ld_n = 1'b1;
        for (int k = 0; k < W; k++) begin
            chk(ser_out, 1'b0, "R5 all stages cleared");
            step(1'b0, 1'b1, 1'b0);
        end
    endtask

    task automatic t_cascade(input logic [2*W-1:0] v);
        cas_mode = 1'b1;
        par_dn = v[2*W-1:W];
        par_up = v[W-1:0];
        step(1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 2*W; k++) begin
            chk(ser_out, v[2*W-1-k], "R7 cascaded order");
            step(1'b0, 1'b1, 1'b0);
        end
        cas_mode = 1'b0;
    endtask

    initial begin
        t_reset_idle();
        t_load_shift(8'hA5, 8'b1011_0010);
        t_load_shift(8'h3C, 8'b0110_1101);
        t_hold(8'h96);
        t_load_priority(8'hF0, 8'h4B);
        t_async_clear();
        t_cascade(16'hC3A5);
        t_cascade(16'h5E81);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (CYCLES_MAX) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog all requirements act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule